// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block moves a set of registers between a sixteen-entry register file and memory, one register per memory beat. Register index 0 to 7 are the data registers D0 to D7 and index 8 to 15 are the address registers A0 to A7. Each operation is set up with a direction, a size, an addressing mode with its base register, a 16-bit selection mask and a start address that has already been resolved. The sequencer walks the mask, issues one read or write per selected register on a valid/ready memory port, writes loaded values into the register file and, where the mode calls for it, writes the final address back into the base address register. It also reports the total cycle cost of the operation.

The memory port follows valid/ready rules. A beat completes only in a cycle where `mem_valid` and `mem_ready` are both high. While `mem_valid` is high and `mem_ready` is low, the sequencer holds the address, direction and size and does not advance, so memory may stall for any number of cycles. For loads, `mem_rdata` is taken in the cycle of the handshake. The register file is read combinationally through `rf_raddr`/`rf_rdata` and is written through `rf_we`. The `start`, `busy`, `done` and `cycles` pins are plain level and pulse signals.

Top module: `regset_mover`

## Requirements
- R1: When mode is not predecrement, or the direction is memory-to-register, mask bit k selects register index k. Bits are served from bit 0 upward. The first access uses the start address, and the address rises by 2 (word, `long_sz`=0) or 4 (long, `long_sz`=1) after each beat.
- R2: For register-to-memory in predecrement mode (mode 4), mask bit k selects register index 15-k, so bit 0 is A7 and bit 15 is D0. Bits are served from bit 0 upward, and the address drops by 2 or 4 before each write.
- R3: A long load writes the 32-bit memory word to the register. A word load writes the low 16 bits sign-extended to 32 bits, into data and address registers alike. A word store drives the low 16 bits of the register with the upper 16 bits zero. A long store drives the whole register.
- R4: In the `done` cycle, a predecrement store or a postincrement load (mode 3) writes the final address to register index 8+`ea_reg`. This write wins over a value loaded into the same register earlier. No other combination writes the register file in that cycle.
- R5: `cycles` equals a base cost plus the number of selected registers times 4 (word) or 8 (long). The store base is 8 for modes 2, 3 and 4, 12 for mode 5 and 14 for mode 6. In mode 7 it is 12 (`ea_reg`=0) or 16 (`ea_reg`=1). The load base is 12 for modes 2, 3 and 4, 16 for mode 5 and 18 for mode 6. In mode 7 it is 16, 20, 16 and 18 for `ea_reg` 0 to 3.
- R6: A zero mask makes no memory access. `done` rises in the first cycle after `start` is taken, and the cost is the base cost only.
- R7: While `mem_valid` is high and `mem_ready` is low, the next cycle still has `mem_valid` high with the same address. No register is written and no state advances.
- R8: `busy` is high from the cycle after `start` is taken through the one-cycle `done` pulse. `start` and all set-up inputs are ignored while `busy` is high.
- R9: After reset, `busy`, `done`, `mem_valid` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| to_regs | input | 1 | 1: memory-to-register, 0: register-to-memory |
| long_sz | input | 1 | 1: 32-bit beats, 0: 16-bit beats |
| ea_mode | input | 3 | Addressing mode (2..7) |
| ea_reg | input | 3 | Base register, or sub-mode when mode is 7 |
| reg_mask | input | 16 | Register selection mask |
| start_addr | input | 32 | Resolved start address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 16 | Cost of the last operation, held until next start |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts or returns the beat |
| mem_write | output | 1 | 1: write beat, 0: read beat |
| mem_long | output | 1 | Beat size, 1 for 32 bits |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid at handshake |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
Two functions can meet on one register in back-to-back cycles, and a third can arrive in the same cycle as a transfer. In a postincrement load whose mask includes the base register, the last loaded value and the address write-back both target index 8+`ea_reg`. The sweep provokes this with full masks and judges it by the write seen in the `done` cycle, which must carry the final address. A second `start` pulse is driven mid-operation, together with altered mask and address inputs, in the same cycle as a live memory beat. It is judged by the beat sequence, the write-back and `cycles` all still matching the first set-up.

// File: rtl/regset_pkg.sv
package regset_pkg;

  localparam int MASK_W = 16;
  localparam int RIDX_W = 4;
  localparam int BASE_W = 5;

  localparam logic [2:0] MODE_POSTINC = 3'd3;
  localparam logic [2:0] MODE_PREDEC  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // fixed overhead of a register-to-memory operation
  function automatic logic [BASE_W-1:0] store_base(input logic [2:0] mode,
                                                   input logic [2:0] sub);
    logic [BASE_W-1:0] b;
    case (mode)
      3'd2, 3'd3, 3'd4: b = 5'd8;
      3'd5:             b = 5'd12;
      3'd6:             b = 5'd14;
      3'd7: begin
        case (sub)
          3'd0:    b = 5'd12;
          3'd1:    b = 5'd16;
          default: b = 5'd0;
        endcase
      end
      default:          b = 5'd0;
    endcase
    return b;
  endfunction

  // fixed overhead of a memory-to-register operation
  function automatic logic [BASE_W-1:0] load_base(input logic [2:0] mode,
                                                  input logic [2:0] sub);
    logic [BASE_W-1:0] b;
    case (mode)
      3'd2, 3'd3, 3'd4: b = 5'd12;
      3'd5:             b = 5'd16;
      3'd6:             b = 5'd18;
      3'd7: begin
        case (sub)
          3'd0:    b = 5'd16;
          3'd1:    b = 5'd20;
          3'd2:    b = 5'd16;
          3'd3:    b = 5'd18;
          default: b = 5'd0;
        endcase
      end
      default:          b = 5'd0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/regset_pick.sv
// Lowest-set-bit selector over the pending mask.
module regset_pick #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  logic [N-1:0] lower_any;

  generate
    for (genvar g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_first
        assign lower_any[g] = 1'b0;
      end else begin : g_rest
        assign lower_any[g] = lower_any[g-1] | vec[g-1];
      end
      assign onehot[g] = vec[g] & ~lower_any[g];
    end
  endgenerate

  assign found = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/regset_cost.sv
// Total cycle cost: base overhead plus per-register charge.
module regset_cost
  import regset_pkg::*;
#(
  parameter int CW = 16,
  parameter int WORD_COST = 4,
  parameter int LONG_COST = 8,
  localparam int NW = $clog2(MASK_W + 1)
) (
  input  logic              to_regs,
  input  logic              long_sz,
  input  logic [2:0]        mode,
  input  logic [2:0]        sub,
  input  logic [MASK_W-1:0] mask,
  output logic [CW-1:0]     cost
);

  logic [NW-1:0]     n_sel;
  logic [BASE_W-1:0] base;
  logic [CW-1:0]     per_reg;

  always_comb begin
    n_sel = '0;
    for (int i = 0; i < MASK_W; i++) begin
      n_sel = n_sel + NW'(mask[i]);
    end
  end

  assign base    = to_regs ? load_base(mode, sub) : store_base(mode, sub);
  assign per_reg = long_sz ? CW'(LONG_COST) : CW'(WORD_COST);
  assign cost    = CW'(base) + CW'(n_sel) * per_reg;

  always_comb begin
    a_r5_cost_floor: assert (cost >= CW'(base));
  end

endmodule

// File: rtl/regset_mover.sv
module regset_mover
  import regset_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  localparam int HW = DW / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_regs,
  input  logic              long_sz,
  input  logic [2:0]        ea_mode,
  input  logic [2:0]        ea_reg,
  input  logic [MASK_W-1:0] reg_mask,
  input  logic [AW-1:0]     start_addr,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     cycles,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic              mem_long,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [DW-1:0]     rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [DW-1:0]     rf_wdata
);

  seq_state_e        state;
  logic              q_load, q_long;
  logic [2:0]        q_mode, q_reg;
  logic [MASK_W-1:0] q_pend;
  logic [AW-1:0]     q_addr;
  logic [CW-1:0]     q_cost;

  logic [CW-1:0]     cost_calc;
  logic              pick_found;
  logic [RIDX_W-1:0] pick_idx;
  logic [MASK_W-1:0] pick_onehot;
  logic [MASK_W-1:0] pend_next;
  logic [RIDX_W-1:0] reg_idx;
  logic [AW-1:0]     step_w, acc_addr, next_addr;
  logic              predec, wb_en, hs;

  regset_cost #(.CW(CW)) u_cost (
    .to_regs (to_regs),
    .long_sz (long_sz),
    .mode    (ea_mode),
    .sub     (ea_reg),
    .mask    (reg_mask),
    .cost    (cost_calc)
  );

  regset_pick #(.N(MASK_W)) u_pick (
    .vec    (q_pend),
    .found  (pick_found),
    .idx    (pick_idx),
    .onehot (pick_onehot)
  );

  // address walk: predecrement stores step down before the beat
  assign predec    = !q_load && (q_mode == MODE_PREDEC);
  assign step_w    = q_long ? AW'(4) : AW'(2);
  assign acc_addr  = predec ? (q_addr - step_w) : q_addr;
  assign next_addr = predec ? acc_addr : (q_addr + step_w);
  assign reg_idx   = predec ? (RIDX_W'(MASK_W - 1) - pick_idx) : pick_idx;
  assign pend_next = q_pend & ~pick_onehot;
  assign wb_en     = predec || (q_load && (q_mode == MODE_POSTINC));

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign cycles    = q_cost;

  assign mem_valid = (state == ST_XFER) && pick_found;
  assign hs        = mem_valid && mem_ready;
  assign mem_write = !q_load;
  assign mem_long  = q_long;
  assign mem_addr  = acc_addr;
  assign mem_wdata = q_long ? rf_rdata : {{(DW-HW){1'b0}}, rf_rdata[HW-1:0]};
  assign rf_raddr  = reg_idx;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = '0;
    rf_wdata = '0;
    if ((state == ST_XFER) && hs && q_load) begin
      rf_we    = 1'b1;
      rf_waddr = reg_idx;
      rf_wdata = q_long ? mem_rdata
                        : {{(DW-HW){mem_rdata[HW-1]}}, mem_rdata[HW-1:0]};
    end else if ((state == ST_FIN) && wb_en) begin
      rf_we    = 1'b1;
      rf_waddr = {1'b1, q_reg};
      rf_wdata = DW'(q_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      q_load <= 1'b0;
      q_long <= 1'b0;
      q_mode <= '0;
      q_reg  <= '0;
      q_pend <= '0;
      q_addr <= '0;
      q_cost <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            q_load <= to_regs;
            q_long <= long_sz;
            q_mode <= ea_mode;
            q_reg  <= ea_reg;
            q_pend <= reg_mask;
            q_addr <= start_addr;
            q_cost <= cost_calc;
            state  <= (reg_mask == '0) ? ST_FIN : ST_XFER;
          end
        end
        ST_XFER: begin
          if (hs) begin
            q_pend <= pend_next;
            q_addr <= next_addr;
            if (pend_next == '0) state <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a stalled beat stays offered unchanged
  a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  // R1: ascending walk advances by the beat size
  a_r1_addr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !predec && (pend_next != '0)) |=> (mem_addr == $past(mem_addr) + $past(step_w)));

  // R2: predecrement walk drops by the beat size
  a_r2_addr_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && predec && (pend_next != '0)) |=> (mem_addr == $past(mem_addr) - $past(step_w)));

  // R8: done is a single pulse inside busy
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: empty mask finishes at once without a beat
  a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (reg_mask == '0)) |=> (done && !mem_valid));

  // R4: the closing write targets an address register
  a_r4_wb_target: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rf_we) |-> rf_waddr[RIDX_W-1]);

endmodule

// File: tb/regset_mover_tb.sv
module regset_mover_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        to_regs = 1'b0;
  logic        long_sz = 1'b0;
  logic [2:0]  ea_mode = '0;
  logic [2:0]  ea_reg = '0;
  logic [15:0] reg_mask = '0;
  logic [31:0] start_addr = '0;
  logic        busy, done;
  logic [15:0] cycles;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_write, mem_long;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;

  int tests = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] rf [16];

  always #10 clk = ~clk;

  regset_mover u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .to_regs(to_regs),
    .long_sz(long_sz), .ea_mode(ea_mode), .ea_reg(ea_reg),
    .reg_mask(reg_mask), .start_addr(start_addr), .busy(busy),
    .done(done), .cycles(cycles), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_long(mem_long),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // register file model
  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rf[i] <= (32'(i) * 32'h1357_9BDF) ^ 32'hA5A5_0F0F;
    end else if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
    end
  end

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[2] ^ a[1], a[14:0]};
  endfunction

  function automatic int exp_cost(input bit ld, input bit lg, input logic [2:0] md,
                                  input logic [2:0] sb, input logic [15:0] mk);
    int b = 0;
    if (ld) begin
      if (md == 2 || md == 3 || md == 4) b = 12;
      else if (md == 5) b = 16;
      else if (md == 6) b = 18;
      else if (md == 7) b = (sb == 1) ? 20 : (sb == 3) ? 18 : 16;
    end else begin
      if (md == 2 || md == 3 || md == 4) b = 8;
      else if (md == 5) b = 12;
      else if (md == 6) b = 14;
      else if (md == 7) b = (sb == 0) ? 12 : 16;
    end
    return b + $countones(mk) * (lg ? 8 : 4);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit ld, input bit lg, input logic [2:0] md,
                        input logic [2:0] sb, input logic [15:0] mk,
                        input logic [31:0] sa, input bit poke);
    logic [15:0] pend = mk;
    logic [31:0] a = sa;
    bit predec = !ld && (md == 3'd4);
    logic [31:0] step = lg ? 32'd4 : 32'd2;
    bit waiting = 0;
    logic [31:0] wait_addr = '0;
    bit finished = 0;
    int iter = 0;
    bit expwb = predec || (ld && md == 3'd3);
    string rq = predec ? "R2" : "R1";
    @(negedge clk);
    to_regs = ld; long_sz = lg; ea_mode = md; ea_reg = sb;
    reg_mask = mk; start_addr = sa; start = 1'b1;
    while (!finished && iter < 200) begin
      int k = -1;
      logic [3:0] ridx = '0;
      logic [31:0] eaddr = '0;
      @(negedge clk);
      iter++;
      start = 1'b0;
      if (iter == 1) begin reg_mask = ~mk; start_addr = 32'hDEAD_0000; end
      if (poke && iter == 3) start = 1'b1;
      mem_ready = lfsr[0] | lfsr[1];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int i = 15; i >= 0; i--) if (pend[i]) k = i;
      if (k >= 0) begin
        ridx  = predec ? 4'(15 - k) : 4'(k);
        eaddr = predec ? (a - step) : a;
        mem_rdata = mem_fn(eaddr);
      end
      #1;
      chk(busy == 1'b1, "R8 busy during op", 32'(busy), 32'd1);
      if (waiting) chk(mem_valid && mem_addr == wait_addr, "R7 stalled beat held",
                       mem_addr, wait_addr);
      if (k >= 0) begin
        chk(mem_valid && !done && mem_addr == eaddr, rq, mem_addr, eaddr);
        chk(mem_write == !ld && mem_long == lg, "R1 beat kind",
            {30'd0, mem_write, mem_long}, {30'd0, !ld, lg});
        if (!ld) chk(mem_wdata == (lg ? rf[ridx] : {16'h0, rf[ridx][15:0]}),
                     "R3 store data", mem_wdata, lg ? rf[ridx] : {16'h0, rf[ridx][15:0]});
        if (mem_ready) begin
          if (ld) begin
            logic [31:0] d = mem_fn(eaddr);
            logic [31:0] ev = lg ? d : {{16{d[15]}}, d[15:0]};
            chk(rf_we && rf_waddr == ridx, "R1 load target", {27'd0, rf_we, rf_waddr},
                {27'd0, 1'b1, ridx});
            chk(rf_wdata == ev, "R3 load data", rf_wdata, ev);
          end else begin
            chk(!rf_we, "R1 no rf write on store", 32'(rf_we), 32'd0);
          end
          pend[k] = 1'b0;
          a = predec ? eaddr : a + step;
          waiting = 0;
        end else begin
          chk(!rf_we, "R7 no write while stalled", 32'(rf_we), 32'd0);
          waiting = 1;
          wait_addr = eaddr;
        end
      end else begin
        chk(done && !mem_valid, mk == 0 ? "R6 empty mask done" : "R1 done after last beat",
            {30'd0, done, mem_valid}, 32'd2);
        chk(cycles == 16'(exp_cost(ld, lg, md, sb, mk)), "R5 cycle cost",
            32'(cycles), 32'(exp_cost(ld, lg, md, sb, mk)));
        if (expwb) begin
          chk(rf_we && rf_waddr == {1'b1, sb}, "R4 write-back target",
              {27'd0, rf_we, rf_waddr}, {27'd0, 1'b1, 1'b1, sb});
          chk(rf_wdata == a, "R4 write-back value", rf_wdata, a);
        end else begin
          chk(!rf_we, "R4 no write-back", 32'(rf_we), 32'd0);
        end
        finished = 1;
      end
    end
    start = 1'b0;
    mem_ready = 1'b0;
    chk(finished, "R8 operation completes", 32'(finished), 32'd1);
    @(negedge clk);
    #1;
    chk(!busy && !done, "R8 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !mem_valid && !rf_we, "R9 reset state",
        {28'd0, busy, done, mem_valid, rf_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!busy && !done && !mem_valid && !rf_we, "R9 idle after reset",
        {28'd0, busy, done, mem_valid, rf_we}, 32'd0);
    for (int ld = 0; ld < 2; ld++) begin
      for (int lg = 0; lg < 2; lg++) begin
        for (int m = 0; m < 9; m++) begin
          logic [2:0] md = (m < 5) ? 3'(m + 2) : 3'd7;
          logic [2:0] sb = (m < 5) ? 3'(m) : 3'(m - 5);
          if (ld == 0 && m > 6) continue;
          for (int mi = 0; mi < 7; mi++) begin
            logic [15:0] mk;
            case (mi)
              0: mk = 16'h0000;
              1: mk = 16'hFFFF;
              2: mk = 16'h8001;
              3: mk = 16'h00F0;
              4: mk = 16'h5A3C;
              5: mk = 16'h0200;
              default: mk = lfsr ^ 16'h9D2B;
            endcase
            run_op(ld[0], lg[0], md, sb, mk, 32'h0000_4000 + 32'(m) * 32'h100, mi == 2 || mi == 4);
          end
        end
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule